// File: doc/BRIEF.md
# Dual Buck Rail Protection Sequencer

This block supervises two synchronous buck channels, called A and B. It brings each channel up through two steps. The first is an over-current calibration phase, which turns on a trip-level current source and then holds the sampled level. The second is a digital soft-start ramp that stands in for the regulation reference. The channel then stays in steady regulation. Analog comparators report digitized flags for each channel: output good, over-voltage, under-voltage, output collapsed and over-current. A die over-temperature flag is shared by both channels.

Any fault on either channel shuts both channels down and latches. How the shutdown happens depends on the fault:
- An over-current or over-temperature fault stops both channels at once.
- An under-voltage fault first runs a soft-stop discharge on the faulting channel.
- An over-voltage fault first holds the low-side switch on until the output has collapsed.

The latch is cleared only by the power-on reset or by taking both shutdown pins low together. The power-good output is open-drain. Next to it, a two-bit code reports which channel caused the fault.

No interface carries a data stream. All pins are plain levels sampled on every clock, so there is no valid/ready handshake and no back-pressure. Bit 0 of every two-bit vector belongs to channel A and bit 1 to channel B.

Top module: `dual_rail_supervisor`

## Requirements
- R1: While `por_n` is low, `ch_en`, `ocs_drive`, `ocs_hold`, `lo_force` and `discharge` are all 0, `ss_code` is 0, `pgood_z` is 0 and `fault_code` is 0.
- R2: Calibration phase:
  - When a channel's `sd_pin` goes high, that channel raises `ocs_drive` one cycle later and holds it for exactly OCS_CYCLES cycles, with `ch_en` and `ocs_hold` at 0.
  - In the next cycle `ocs_drive` falls, `ocs_hold` and `ch_en` rise, and `ss_code` starts at 0.
- R3: Soft-start ramp:
  - During the ramp, `ss_code` never decreases.
  - It reaches full scale (all ones) within SS_CYCLES clocks of ramp start, and no sooner than SS_CYCLES minus two ramp steps.
  - It then stays at full scale while the channel regulates.
- R4: Shutdown pin:
  - A low `sd_pin` turns its channel off at the next clock (`ch_en`=0, `ss_code`=0) and leaves the other channel running.
  - Raising the pin again restarts calibration and soft-start.
- R5: Under-voltage:
  - `fb_under` is ignored during calibration and ramp.
  - In regulation it stops the channel and raises `discharge` until `vout_dead` is seen.
  - Two cycles after that, both channels are latched off.
- R6: Over-voltage:
  - `fb_over` on an enabled channel raises `lo_force` for that channel and drops its `ch_en`.
  - `lo_force` stays high after `fb_over` clears, until `vout_dead` is seen.
  - Two cycles after that, `lo_force` and `ch_en` are 0 on both channels and the latch is set.
- R7: `ot_flag` latches both channels off, with `ch_en` 0 two cycles after it is sampled.
- R8: `oc_trip` on a ramping or regulating channel sets the latch in the next cycle, and both channels are off one cycle later.
- R9: Latch clearing and restart:
  - While latched, toggling only one `sd_pin` leaves both channels off and keeps `fault_code`.
  - Both `sd_pin` low together clears the latch and the fault code, and raising the pins restarts calibration.
- R10: Power-good:
  - `pgood_z` rises only after both channels regulate with `fb_good`=11 for PG_DELAY consecutive cycles.
  - A loss of `fb_good` pulls it low after PG_DELAY cycles.
  - A fault, or either channel not regulating, pulls it low at once.
- R11: `fault_code` encoding:
  - 00 means no fault, 01 a fault raised by channel A, 10 by channel B.
  - 11 means both channels raised a fault, or over-temperature. Channel A's bit is set whenever A faults.
  - The code is held until the latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the latch |
| sd_pin | input | 2 | Shutdown pin level per channel, 1 = enabled |
| fb_good | input | 2 | Feedback above 90 % of reference |
| fb_over | input | 2 | Feedback above 120 % of reference |
| fb_under | input | 2 | Feedback below 70 % of reference |
| vout_dead | input | 2 | Output below 5 % of nominal |
| oc_trip | input | 2 | Over-current comparator |
| ot_flag | input | 1 | Die over-temperature |
| ch_en | output | 2 | Channel switching enable |
| ocs_drive | output | 2 | Over-current setting current source on |
| ocs_hold | output | 2 | Hold sampled over-current trip level |
| lo_force | output | 2 | Force low-side switch on |
| discharge | output | 2 | Soft-stop discharge switch on |
| ss_code | output | 2 x SS_BITS | Soft-start reference code per channel |
| pgood_z | output | 1 | Open-drain power-good, 1 = released |
| fault_code | output | 2 | Faulting channel code |

## Verification
A wrong internal state shows at the ports within one or two clocks.

- A channel stuck in the wrong phase shows up as a wrong mix of `ocs_drive`, `ocs_hold`, `ch_en`, `lo_force` and `discharge` on the very next clock.
- A broken latch shows as `ch_en` coming back, or `fault_code` changing, after a single-pin toggle.
- A wrong ramp divider shows as a ramp length outside its window.
- A bad power-good filter releases or pulls low one or more cycles away from the PG_DELAY boundary that the checks sample on both sides.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    S_OFF      = 3'd0,
    S_SAMPLE   = 3'd1,
    S_RAMP     = 3'd2,
    S_RUN      = 3'd3,
    S_SOFTSTOP = 3'd4,
    S_CLAMP    = 3'd5,
    S_LATCH    = 3'd6
  } rail_state_t;
endpackage

// File: rtl/rail_seq.sv
module rail_seq
  import dual_rail_pkg::*;
#(
  parameter int SS_BITS    = 4,
  parameter int SS_DIV     = 4,
  parameter int OCS_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_en,
  input  logic               locked,
  input  logic               fb_over,
  input  logic               fb_under,
  input  logic               vout_dead,
  input  logic               oc_trip,
  output logic               ch_en,
  output logic               ocs_drive,
  output logic               ocs_hold,
  output logic               lo_force,
  output logic               discharge,
  output logic [SS_BITS-1:0] ss_code,
  output logic               ev_src,
  output logic               ev_lock,
  output logic               running
);
  localparam int CMAX = (SS_DIV > OCS_CYCLES) ? SS_DIV : OCS_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [SS_BITS-1:0] FULL = {SS_BITS{1'b1}};

  rail_state_t       state;
  logic [CW-1:0]     cnt;
  logic [SS_BITS-1:0] ss_q;
  logic              active;

  assign active = (state == S_RAMP) || (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
      ss_q  <= '0;
    end else if (locked) begin
      state <= S_LATCH;
      cnt   <= '0;
      ss_q  <= '0;
    end else if (state == S_LATCH || !pin_en) begin
      state <= S_OFF;
      cnt   <= '0;
      ss_q  <= '0;
    end else begin
      case (state)
        S_OFF: begin
          state <= S_SAMPLE;
          cnt   <= '0;
        end
        S_SAMPLE: begin
          if (cnt == CW'(OCS_CYCLES - 1)) begin
            state <= S_RAMP;
            cnt   <= '0;
            ss_q  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RAMP: begin
          if (fb_over) begin
            state <= S_CLAMP;
          end else if (ss_q == FULL) begin
            state <= S_RUN;
          end else if (cnt == CW'(SS_DIV - 1)) begin
            cnt  <= '0;
            ss_q <= ss_q + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (fb_over)       state <= S_CLAMP;
          else if (fb_under) state <= S_SOFTSTOP;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ch_en     = active;
    ocs_drive = (state == S_SAMPLE);
    ocs_hold  = active;
    lo_force  = (state == S_CLAMP);
    discharge = (state == S_SOFTSTOP);
    running   = (state == S_RUN);
    ss_code   = (state == S_RUN) ? FULL : ((state == S_RAMP) ? ss_q : '0);
    ev_src    = active && (oc_trip || fb_over || ((state == S_RUN) && fb_under));
    ev_lock   = (active && oc_trip) ||
                (((state == S_SOFTSTOP) || (state == S_CLAMP)) && vout_dead);
  end

  // R2: the ramp is entered only from a completed calibration phase
  a_r2_ramp_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP && $past(state) != S_RAMP) |->
      ($past(state) == S_SAMPLE && $past(cnt) == CW'(OCS_CYCLES - 1)));

  // R3: ramp code never steps down while ramping
  a_r3_ramp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAMP && $past(state) == S_RAMP) |-> (ss_q >= $past(ss_q)));

  // R6: the low-side clamp holds until the output has collapsed
  a_r6_clamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CLAMP && !vout_dead && !locked && pin_en) |=> lo_force);
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == CW'(DELAY - 1)) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: the filtered level only rises on a sustained high input
  a_r10_filter_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(d));
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
  import dual_rail_pkg::*;
#(
  parameter int SS_BITS    = 4,
  parameter int SS_CYCLES  = 64,
  parameter int OCS_CYCLES = 4,
  parameter int PG_DELAY   = 8
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic [NUM_CH-1:0]              sd_pin,
  input  logic [NUM_CH-1:0]              fb_good,
  input  logic [NUM_CH-1:0]              fb_over,
  input  logic [NUM_CH-1:0]              fb_under,
  input  logic [NUM_CH-1:0]              vout_dead,
  input  logic [NUM_CH-1:0]              oc_trip,
  input  logic                           ot_flag,
  output logic [NUM_CH-1:0]              ch_en,
  output logic [NUM_CH-1:0]              ocs_drive,
  output logic [NUM_CH-1:0]              ocs_hold,
  output logic [NUM_CH-1:0]              lo_force,
  output logic [NUM_CH-1:0]              discharge,
  output logic [NUM_CH-1:0][SS_BITS-1:0] ss_code,
  output logic                           pgood_z,
  output logic [NUM_CH-1:0]              fault_code
);
  localparam int SS_DIV_RAW = SS_CYCLES / (2 ** SS_BITS);
  localparam int SS_DIV     = (SS_DIV_RAW < 1) ? 1 : SS_DIV_RAW;

  logic [NUM_CH-1:0] ev_src, ev_lock, running;
  logic              locked, lock_set, all_off_pins, pg_raw, pg_q, fault_any;
  logic [NUM_CH-1:0] src_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rail_seq #(
      .SS_BITS(SS_BITS), .SS_DIV(SS_DIV), .OCS_CYCLES(OCS_CYCLES)
    ) i_seq (
      .clk(clk), .rst_n(por_n), .pin_en(sd_pin[g]), .locked(locked),
      .fb_over(fb_over[g]), .fb_under(fb_under[g]), .vout_dead(vout_dead[g]),
      .oc_trip(oc_trip[g]), .ch_en(ch_en[g]), .ocs_drive(ocs_drive[g]),
      .ocs_hold(ocs_hold[g]), .lo_force(lo_force[g]), .discharge(discharge[g]),
      .ss_code(ss_code[g]), .ev_src(ev_src[g]), .ev_lock(ev_lock[g]),
      .running(running[g])
    );
  end

  assign lock_set     = ot_flag || (|ev_lock);
  assign all_off_pins = (sd_pin == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      locked <= 1'b0;
      src_q  <= '0;
    end else begin
      if (lock_set)          locked <= 1'b1;
      else if (all_off_pins) locked <= 1'b0;
      if (all_off_pins && !lock_set) src_q <= '0;
      else src_q <= src_q | ev_src | {NUM_CH{ot_flag}};
    end
  end

  assign fault_any  = locked || (src_q != '0);
  assign fault_code = src_q;
  assign pg_raw     = (&running) && (&fb_good) && !fault_any;

  pg_deglitch #(.DELAY(PG_DELAY)) i_pg (
    .clk(clk), .rst_n(por_n), .d(pg_raw), .q(pg_q)
  );

  assign pgood_z = pg_q && !fault_any && (&running);

  // R8: once latched, both channels are off on the following cycle
  a_r8_lock_turns_off: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> (ch_en == '0 && lo_force == '0 && discharge == '0));

  // R9: the latch survives unless both shutdown pins are low together
  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!por_n)
    (locked && !all_off_pins) |=> locked);
endmodule

// File: tb/test_dual_rail_supervisor.sv
module test_dual_rail_supervisor;
  localparam int SS_BITS = 4, SS_CYCLES = 64, OCS_CYCLES = 4, PG_DELAY = 8;
  localparam int DIV = SS_CYCLES / (2 ** SS_BITS);
  localparam int FULL = (2 ** SS_BITS) - 1;

  logic clk = 1'b0, por_n = 1'b0, ot_flag = 1'b0;
  logic [1:0] sd_pin = '0, fb_good = '0, fb_over = '0, fb_under = '0;
  logic [1:0] vout_dead = '0, oc_trip = '0;
  logic [1:0] ch_en, ocs_drive, ocs_hold, lo_force, discharge, fault_code;
  logic [1:0][SS_BITS-1:0] ss_code;
  logic pgood_z;

  always #10 clk = ~clk;

  dual_rail_supervisor #(.SS_BITS(SS_BITS), .SS_CYCLES(SS_CYCLES),
    .OCS_CYCLES(OCS_CYCLES), .PG_DELAY(PG_DELAY)) i_dual_rail_supervisor (
    .clk(clk), .por_n(por_n), .sd_pin(sd_pin), .fb_good(fb_good),
    .fb_over(fb_over), .fb_under(fb_under), .vout_dead(vout_dead),
    .oc_trip(oc_trip), .ot_flag(ot_flag), .ch_en(ch_en),
    .ocs_drive(ocs_drive), .ocs_hold(ocs_hold), .lo_force(lo_force),
    .discharge(discharge), .ss_code(ss_code), .pgood_z(pgood_z),
    .fault_code(fault_code));

  typedef struct { string req; int sel; int exp; } item_t;
  item_t sb_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  function automatic int observe(int sel);
    case (sel)
      0: return int'(ch_en);
      1: return int'(ocs_drive);
      2: return int'(ocs_hold);
      3: return int'(lo_force);
      4: return int'(discharge);
      5: return int'(pgood_z);
      6: return int'(fault_code);
      7: return int'(ss_code[0]);
      default: return int'(ss_code[1]);
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic dchk(string req, int act, int exp, bit ok);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        act = observe(it.sel);
        n_checks++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic wait_ramp(output int cycles, output bit mono);
    int prev;
    cycles = 0; mono = 1; prev = int'(ss_code[1]);
    while (!(int'(ss_code[0]) == FULL && int'(ss_code[1]) == FULL) && cycles < 300) begin
      tick(1);
      cycles++;
      if (int'(ss_code[1]) < prev) mono = 0;
      prev = int'(ss_code[1]);
    end
  endtask

  task automatic restart();
    int c; bit m;
    vout_dead = '0; fb_over = '0; fb_under = '0; oc_trip = '0; ot_flag = 1'b0;
    sd_pin = 2'b00; tick(2);
    sd_pin = 2'b11; tick(1);
    wait_ramp(c, m);
    tick(PG_DELAY + 2);
    chk("R10 pgood after restart", 5, 1);
    tick(1);
  endtask

  initial begin
    int cyc;
    bit mono;
    fb_good = 2'b11;
    tick(3);
    chk("R1 ch_en in reset", 0, 0); chk("R1 ss A in reset", 7, 0);
    chk("R1 pgood in reset", 5, 0); chk("R1 fault in reset", 6, 0);
    chk("R1 ocs_drive in reset", 1, 0);
    por_n = 1'b1; tick(2);

    // R2 calibration phase
    sd_pin = 2'b11; tick(1);
    chk("R2 drive on", 1, 3); chk("R2 hold off", 2, 0); chk("R2 ch_en off", 0, 0);
    tick(OCS_CYCLES - 1);
    chk("R2 drive last cycle", 1, 3);
    tick(1);
    chk("R2 drive off", 1, 0); chk("R2 hold on", 2, 3);
    chk("R2 ch_en on", 0, 3); chk("R2 ramp start", 7, 0);

    // R5 under-voltage ignored while ramping
    fb_under = 2'b11; tick(3);
    chk("R5 no discharge in ramp", 4, 0); chk("R5 ch_en kept in ramp", 0, 3);
    fb_under = 2'b00;

    // R3 ramp length and monotonic code
    wait_ramp(cyc, mono);
    cyc += 3;
    dchk("R3 ramp length", cyc, SS_CYCLES,
         (cyc <= SS_CYCLES) && (cyc >= SS_CYCLES - 2 * DIV));
    dchk("R3 ramp monotonic", int'(mono), 1, mono);
    tick(1);
    chk("R3 A full", 7, FULL); chk("R3 B full", 8, FULL);
    chk("R10 pgood not yet", 5, 0);
    tick(PG_DELAY - 1);
    chk("R10 pgood before delay", 5, 0);
    tick(1);
    chk("R10 pgood released", 5, 1);

    // R10 loss of feedback good filtered
    fb_good = 2'b10; tick(PG_DELAY - 1);
    chk("R10 pgood held during filter", 5, 1);
    tick(1);
    chk("R10 pgood pulled low", 5, 0);
    fb_good = 2'b11; tick(PG_DELAY);
    chk("R10 pgood back", 5, 1);

    // R4 shutdown of channel B only
    sd_pin = 2'b01; tick(1);
    chk("R4 B off", 0, 1); chk("R4 B ss zero", 8, 0); chk("R4 A full", 7, FULL);
    chk("R10 pgood low when B off", 5, 0);
    sd_pin = 2'b11; tick(1);
    chk("R4 B recalibrates", 1, 2);
    wait_ramp(cyc, mono);
    tick(PG_DELAY + 2);
    chk("R4 pgood after B restart", 5, 1);

    // R6 over-voltage on A
    fb_over = 2'b01; tick(1);
    chk("R6 lo_force A", 3, 1); chk("R6 A disabled", 0, 2);
    chk("R11 code A", 6, 1); chk("R10 pgood low on fault", 5, 0);
    fb_over = 2'b00; tick(3);
    chk("R6 clamp held", 3, 1);
    vout_dead = 2'b01; tick(2);
    chk("R6 gates low", 3, 0); chk("R6 both off", 0, 0); chk("R6 code kept", 6, 1);
    restart();

    // R8 over-current on B and R9 single pin toggle
    oc_trip = 2'b10; tick(1);
    chk("R8 code B", 6, 2); chk("R8 pgood low", 5, 0);
    tick(1);
    chk("R8 both off", 0, 0);
    oc_trip = 2'b00;
    sd_pin = 2'b10; tick(2); sd_pin = 2'b11; tick(2);
    chk("R9 still off", 0, 0); chk("R9 no calibration", 1, 0); chk("R9 code held", 6, 2);
    sd_pin = 2'b00; tick(2);
    chk("R9 code cleared", 6, 0);
    sd_pin = 2'b11; tick(1);
    chk("R9 restart calibrates", 1, 3);
    wait_ramp(cyc, mono);
    tick(PG_DELAY + 2);
    chk("R9 pgood after clear", 5, 1);

    // R5 under-voltage on B in regulation
    fb_under = 2'b10; tick(1);
    chk("R5 discharge B", 4, 2); chk("R5 B stopped", 0, 1); chk("R11 code B uv", 6, 2);
    fb_under = 2'b00; tick(2);
    chk("R5 discharge held", 4, 2);
    vout_dead = 2'b10; tick(2);
    chk("R5 both latched", 0, 0); chk("R5 discharge ends", 4, 0);
    restart();

    // R11 both channels over-current
    oc_trip = 2'b11; tick(1);
    chk("R11 code both", 6, 3);
    oc_trip = 2'b00;
    restart();

    // R7 over-temperature
    ot_flag = 1'b1; tick(2);
    chk("R7 both off", 0, 0); chk("R7 code", 6, 3);
    ot_flag = 1'b0; sd_pin = 2'b00; tick(2);
    chk("R11 cleared with latch", 6, 0);
    sd_pin = 2'b11; tick(1);
    chk("R7 restart calibrates", 1, 3);
    tick(2);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule